// File: doc/BRIEF.md
# Priority Slot Access Scheduler

This block decides when a station on a shared, carrier-sensed medium may begin a transmission. When a frame on the wire ends, it times an inter-frame gap. It then walks a fixed series of eight priority windows, starting at the highest class (7) and counting down to 0. A station whose pending frame carries class P is granted the medium at the first cycle of window P. It loses that chance if carrier appears first, because that means a higher class has already claimed the wire. A lower class therefore always yields to a higher one without any collision.

When all eight windows pass with no transmission, the scheduler rests in an idle state. A frame that becomes pending while idle is granted at once. A collision input suppresses or aborts the grant and sends the scheduler back to waiting for the end of the frame and a fresh gap. The gap and window lengths are runtime inputs counted in clock cycles. Writing zero to either one selects its default length.

Top module: `prio_slot_sched`

## Requirements
- R1: While reset is low, `grant` and `deferring` are 0. The first gap starts counting at the first clock edge after reset is released.
- R2: Let the end of a frame be sampled at clock edge E. Window k then begins at edge E+G+(7−k)·S, where G is the gap length and S is the window length. A pending frame of class P gets `grant` high in the cycle that follows edge E+G+(7−P)·S.
- R3: The pending flag and the class are captured at the last gap edge. They are held for the whole window series, so later changes to either one do not move or cancel that series' grant.
- R4: Carrier seen during the window series before the station's own window stops the grant. `deferring` is then 1 until an end-of-frame pulse, which starts a new gap.
- R5: Carrier seen during the gap restarts deferral. `deferring` is 1 until end of frame, and the gap is then timed again from the start.
- R6: When window 0 ends with no transmission, the scheduler goes idle with `deferring` at 0. A frame that becomes pending while idle is granted in the same cycle it appears.
- R7: `grant` is a single-cycle pulse. No second grant occurs until an end-of-frame pulse has been followed by a new gap and window series.
- R8: `collision` held high in a cycle forces `grant` low in that cycle. A collision during a grant, or while transmitting, puts the scheduler into deferral until end of frame.
- R9: A value of 0 on `gap_len` selects 29 cycles, and a value of 0 on `slot_len` selects 21 cycles. Any other value is used as the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gap_len | input | 8 | Inter-frame gap length in cycles (0 = default 29) |
| slot_len | input | 8 | Priority window length in cycles (0 = default 21) |
| carrier | input | 1 | Carrier sensed on the medium |
| eof | input | 1 | One-cycle pulse marking the end of the frame on the wire |
| collision | input | 1 | Collision reported by the detector |
| tx_pending | input | 1 | A frame is waiting to be sent |
| tx_prio | input | 3 | Class of the waiting frame, 7 highest |
| grant | output | 1 | One-cycle permission to start transmitting |
| deferring | output | 1 | Medium is held by another station or a collision |

## Verification
The assertions assume that `eof` comes as a single-cycle pulse with `carrier` low in the same cycle. They also assume that `gap_len` and `slot_len` change only while a frame is on the wire, never during a gap or a window series. The stimulus drives every input a few nanoseconds after a clock edge. It raises `eof` only for one cycle, once a frame or a collision episode is over. It reprograms the lengths only while the scheduler is transmitting. Carrier and collision are raised only at chosen points, namely during a gap, in the middle of a window, in the grant cycle and during transmission, so each deferral path is reached on purpose.

// File: rtl/prio_slot_sched.sv
module prio_slot_sched #(
  parameter int CNT_W    = 8,
  parameter int PRIO_W   = 3,
  parameter int DEF_GAP  = 29,
  parameter int DEF_SLOT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  gap_len,
  input  logic [CNT_W-1:0]  slot_len,
  input  logic              carrier,
  input  logic              eof,
  input  logic              collision,
  input  logic              tx_pending,
  input  logic [PRIO_W-1:0] tx_prio,
  output logic              grant,
  output logic              deferring
);
  localparam logic [PRIO_W-1:0] TOP = {PRIO_W{1'b1}};

  typedef enum logic [2:0] {S_GAP, S_SLOT, S_IDLE, S_TX, S_BUSY} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [PRIO_W-1:0] slot, prio_q;
  logic              pend_q;

  wire [CNT_W-1:0] gap_eff  = (gap_len  == '0) ? CNT_W'(DEF_GAP)  : gap_len;
  wire [CNT_W-1:0] slot_eff = (slot_len == '0) ? CNT_W'(DEF_SLOT) : slot_len;
  wire             quiet    = !carrier && !collision;

  assign grant = quiet &&
                 ((st == S_SLOT && cnt == '0 && pend_q && slot == prio_q) ||
                  (st == S_IDLE && tx_pending));
  assign deferring = (st == S_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_GAP;
      cnt    <= '0;
      slot   <= TOP;
      prio_q <= '0;
      pend_q <= 1'b0;
    end else begin
      case (st)
        S_GAP:
          if (!quiet) st <= S_BUSY;
          else if (cnt == gap_eff - 1'b1) begin
            st     <= S_SLOT;
            cnt    <= '0;
            slot   <= TOP;
            prio_q <= tx_prio;
            pend_q <= tx_pending;
          end else cnt <= cnt + 1'b1;
        S_SLOT:
          if (grant) st <= S_TX;
          else if (!quiet) st <= S_BUSY;
          else if (cnt == slot_eff - 1'b1) begin
            cnt <= '0;
            if (slot == '0) st <= S_IDLE;
            else slot <= slot - 1'b1;
          end else cnt <= cnt + 1'b1;
        S_IDLE:
          if (grant) st <= S_TX;
          else if (!quiet) st <= S_BUSY;
        S_TX:
          if (collision) st <= S_BUSY;
          else if (eof) begin
            st  <= S_GAP;
            cnt <= '0;
          end
        S_BUSY:
          if (eof) begin
            st  <= S_GAP;
            cnt <= '0;
          end
        default: st <= S_BUSY;
      endcase
    end
  end

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  // R4
  defer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deferring |-> !grant);

  // R8
  coll_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> !grant);

  // R8
  tx_coll_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && collision) |=> deferring);

  // R5
  gap_carrier_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && carrier) |=> deferring);

  // R1
  always_ff @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!grant && !deferring);
endmodule

// File: tb/prio_slot_sched_tb.sv
module prio_slot_sched_tb;
  logic       clk = 0, rst_n = 0;
  logic [7:0] gap_len = 8'd5, slot_len = 8'd3;
  logic       carrier = 0, eof = 0, collision = 0, tx_pending = 0;
  logic [2:0] tx_prio = 0;
  logic       grant, deferring;

  int checks = 0, fails = 0, cyc = 0, last_g = 0;
  int exp_q[$];
  string exp_r[$];

  prio_slot_sched u_dut (.clk, .rst_n, .gap_len, .slot_len, .carrier, .eof,
                         .collision, .tx_pending, .tx_prio, .grant, .deferring);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every grant is matched against the scoreboard
  always @(negedge clk) if (rst_n && grant) begin
    checks++;
    last_g = cyc;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R7 unexpected grant: actual cycle %0d expected none", cyc);
    end else begin
      int e;
      string r;
      e = exp_q.pop_front();
      r = exp_r.pop_front();
      if (e != cyc) begin
        fails++;
        $display("FAIL %s grant cycle: actual %0d expected %0d", r, cyc, e);
      end
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic go_to(int n);
    do begin @(posedge clk); #2; end while (cyc < n);
  endtask

  function automatic int g(); return (gap_len == 0) ? 29 : int'(gap_len); endfunction
  function automatic int s(); return (slot_len == 0) ? 21 : int'(slot_len); endfunction

  task automatic pulse_eof(output int e);
    eof = 1;
    e = cyc + 1;
    go_to(e);
    eof = 0;
  endtask

  task automatic run(int p, string r);
    int e, t;
    tx_prio = 3'(p);
    tx_pending = 1;
    pulse_eof(e);
    t = e + g() + (7 - p) * s();
    exp_q.push_back(t); exp_r.push_back(r);
    go_to(t + 1);
    tx_pending = 0;
    chk(grant == 0 && exp_q.size() == 0, "R7", grant, 0);
  endtask

  task automatic run_idle();
    int e;
    tx_pending = 0;
    pulse_eof(e);
    go_to(e + g() + 8 * s() + 2);
    chk(deferring == 0 && grant == 0, "R6", deferring, 0);
  endtask

  initial begin
    int e, t;
    go_to(3);
    chk(grant == 0 && deferring == 0, "R1", deferring, 0);
    rst_n = 1;
    go_to(cyc + 5 + 24 + 4);
    chk(deferring == 0, "R6", deferring, 0);
    // R6: pending while idle is granted in the same cycle
    tx_prio = 3; tx_pending = 1;
    exp_q.push_back(cyc); exp_r.push_back("R6");
    go_to(cyc + 1);
    tx_pending = 0;
    // R2 at both ends and in the middle
    run(7, "R2");
    run(0, "R2");
    run(4, "R2");
    // R3: class and flag change after capture
    tx_prio = 2; tx_pending = 1;
    pulse_eof(e);
    t = e + 5 + 15;
    exp_q.push_back(t); exp_r.push_back("R3");
    go_to(e + 7);
    tx_prio = 6; tx_pending = 0;
    go_to(t + 1);
    // R4: carrier inside window 5 while class 2 is waiting
    tx_prio = 2; tx_pending = 1;
    pulse_eof(e);
    go_to(e + 11);
    carrier = 1;
    go_to(e + 12);
    chk(deferring == 1, "R4", deferring, 1);
    go_to(e + 30);
    chk(deferring == 1 && exp_q.size() == 0, "R4", deferring, 1);
    carrier = 0;
    pulse_eof(e);
    t = e + 5 + 15;
    exp_q.push_back(t); exp_r.push_back("R4");
    go_to(t + 1);
    // R5: carrier during the gap
    tx_prio = 5;
    pulse_eof(e);
    go_to(e + 2);
    carrier = 1;
    go_to(e + 3);
    carrier = 0;
    chk(deferring == 1, "R5", deferring, 1);
    go_to(e + 20);
    chk(deferring == 1, "R5", deferring, 1);
    pulse_eof(e);
    t = e + 5 + 6;
    exp_q.push_back(t); exp_r.push_back("R5");
    go_to(t + 1);
    tx_pending = 0;
    // R8: collision while transmitting
    collision = 1;
    go_to(cyc + 1);
    collision = 0;
    chk(deferring == 1, "R8", deferring, 1);
    run(1, "R8");
    // R8: collision in the grant cycle (idle path)
    run_idle();
    tx_prio = 1; tx_pending = 1; collision = 1;
    go_to(cyc + 1);
    collision = 0;
    chk(deferring == 1, "R8", deferring, 1);
    go_to(cyc + 3);
    chk(deferring == 1, "R8", deferring, 1);
    pulse_eof(e);
    t = e + 5 + 18;
    exp_q.push_back(t); exp_r.push_back("R8");
    go_to(t + 1);
    tx_pending = 0;
    // R9: zero lengths select defaults
    gap_len = 0; slot_len = 0;
    run(6, "R9");
    run(0, "R9");
    gap_len = 8'd2; slot_len = 8'd1;
    run(3, "R9");
    go_to(cyc + 4);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule